// File: doc/BRIEF.md
# Monotonic Security Level Gate

This block keeps a three-level software protection setting and rules on every operation request that a programming front end presents to it. Each request carries an operation class, a data byte and a select bit, and is marked by a single-cycle strobe. One clock later the block answers with a grant flag. When it refuses, it also gives an ASCII error byte that the front end sends back to the host, followed by its own CR and LF.

The protection setting is held as a small state machine with three states. LVL_OPEN is encoded FFh and is the reset state. LVL_WPROT is encoded FEh and forbids writes. LVL_LOCKED is encoded FCh and forbids both reads and writes. The named transitions are as follows:
- RAISE_WP moves LVL_OPEN to LVL_WPROT.
- RAISE_LK moves LVL_OPEN or LVL_WPROT to LVL_LOCKED.
- WIPE moves any state to LVL_OPEN.

A granted security write fires RAISE_WP or RAISE_LK. A full erase fires WIPE. No other command lowers the level. The same full erase also restores two boot configuration bytes that the block holds: the boot status byte and the boot vector. A granted configuration write loads one of these two bytes.

Top module: `sec_level_gate`

## Requirements
- R1: After reset, sec_level is FFh, boot_status is FFh, boot_vector is FCh, and rsp_valid is low.
- R2: Every cycle with req_valid high gives exactly one cycle of rsp_valid high on the next cycle. While rsp_valid is low, rsp_grant is 0 and rsp_err is 00h.
- R3: Operation codes on req_op are as follows:
  - 0 is a memory read.
  - 1 is a memory write.
  - 2 is a block erase.
  - 3 is a configuration write.
  - 4 is a configuration read.
  - 5 is a security write.
  - 6 is an identity read.
  - 7 is a full erase.
  - 8 is a blank check.

  At level FFh every one of these is granted, except a security write that fails R7.
- R4: At level FEh:
  - Memory write, block erase and configuration write are refused with rsp_err 50h ('P').
  - Memory read, configuration read, identity read, blank check and full erase are granted.
- R5: At level FCh:
  - Memory read and configuration read are refused with 4Ch ('L').
  - Memory write, block erase, configuration write and security write are refused with 50h.
  - Identity read, blank check and full erase are granted.
- R6: Levels are ranked FFh < FEh < FCh. A security write whose req_data is a level of strictly higher rank is granted. sec_level takes that value on the same edge that raises rsp_valid.
- R7: A security write whose req_data is refused with 50h, and sec_level does not change, in either of these cases:
  - req_data is a level of equal or lower rank.
  - req_data is not one of FFh, FEh or FCh.
- R8: A full erase is granted at every level. On the response edge it sets sec_level to FFh, boot_status to FFh and boot_vector to FCh.
- R9: A granted configuration write loads req_data into boot_status when req_cfg_sel is 0, and into boot_vector when req_cfg_sel is 1. A refused configuration write leaves both bytes unchanged.
- R10: Operation codes 9 to 15 are refused with 50h and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, one request per high cycle |
| req_op | input | 4 | Operation class code |
| req_data | input | 8 | Requested level code or configuration value |
| req_cfg_sel | input | 1 | Configuration byte select, 0 for status and 1 for vector |
| rsp_valid | output | 1 | Response present, one cycle after the strobe |
| rsp_grant | output | 1 | Request permitted |
| rsp_err | output | 8 | ASCII refusal code, 00h when granted or idle |
| sec_level | output | 8 | Current encoded protection level |
| boot_status | output | 8 | Boot status byte |
| boot_vector | output | 8 | Boot vector byte |

## Verification
Directed sequences cover the main function:
- Each of the three levels is reached in turn, and every operation class is applied at each level. This separates the read-refusal code from the write-refusal code and shows which classes stay free.
- Security writes are tried with every level code plus a non-level byte, from each level. This tells a strict raise apart from an equal, lower or malformed request.
- Configuration writes are placed before and after protection is raised. The boot bytes then show whether a refused write left any trace.

Seeded random requests then mix all sixteen codes, including the reserved ones, with random data. Back-to-back strobes and full erases return the level to open repeatedly, so the downward transition is tested under varied histories.

// File: rtl/sec_gate_pkg.sv
package sec_gate_pkg;

    localparam int BYTE_W = 8;
    localparam int OP_W   = 4;

    // operation class codes
    localparam logic [OP_W-1:0] OP_MEM_RD     = 4'd0;
    localparam logic [OP_W-1:0] OP_MEM_WR     = 4'd1;
    localparam logic [OP_W-1:0] OP_BLK_ERASE  = 4'd2;
    localparam logic [OP_W-1:0] OP_CFG_WR     = 4'd3;
    localparam logic [OP_W-1:0] OP_CFG_RD     = 4'd4;
    localparam logic [OP_W-1:0] OP_SEC_WR     = 4'd5;
    localparam logic [OP_W-1:0] OP_ID_RD      = 4'd6;
    localparam logic [OP_W-1:0] OP_FULL_ERASE = 4'd7;
    localparam logic [OP_W-1:0] OP_BLANK_CHK  = 4'd8;

    // encoded protection levels
    localparam logic [BYTE_W-1:0] CODE_OPEN   = 8'hFF;
    localparam logic [BYTE_W-1:0] CODE_WPROT  = 8'hFE;
    localparam logic [BYTE_W-1:0] CODE_LOCKED = 8'hFC;

    // reply bytes
    localparam logic [BYTE_W-1:0] REPLY_NONE    = 8'h00;
    localparam logic [BYTE_W-1:0] REPLY_WR_DENY = 8'h50;
    localparam logic [BYTE_W-1:0] REPLY_RD_DENY = 8'h4C;

    typedef enum logic [1:0] {
        LVL_OPEN   = 2'd0,
        LVL_WPROT  = 2'd1,
        LVL_LOCKED = 2'd2
    } lvl_e;

    // rank of a level code: 0..2, 3 for a byte that is no level
    function automatic logic [1:0] code_rank(input logic [BYTE_W-1:0] code);
        logic [1:0] r;
        unique case (code)
            CODE_OPEN:   r = 2'd0;
            CODE_WPROT:  r = 2'd1;
            CODE_LOCKED: r = 2'd2;
            default:     r = 2'd3;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sec_level_fsm.sv
module sec_level_fsm
    import sec_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise_i,
    input  lvl_e              target_i,
    input  logic              wipe_i,
    output lvl_e              lvl_o,
    output logic [BYTE_W-1:0] code_o
);

    lvl_e cur_q;
    lvl_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= LVL_OPEN;
        end else begin
            cur_q <= nxt;
        end
    end

    // transitions: WIPE has priority, RAISE_WP / RAISE_LK only move up
    always_comb begin
        nxt = cur_q;
        if (wipe_i) begin
            nxt = LVL_OPEN;
        end else if (raise_i) begin
            unique case (cur_q)
                LVL_OPEN: begin
                    if (target_i != LVL_OPEN) begin
                        nxt = target_i;
                    end
                end
                LVL_WPROT: begin
                    if (target_i == LVL_LOCKED) begin
                        nxt = LVL_LOCKED;
                    end
                end
                LVL_LOCKED: nxt = LVL_LOCKED;
                default:    nxt = LVL_OPEN;
            endcase
        end
    end

    // outputs
    always_comb begin
        lvl_o = cur_q;
        unique case (cur_q)
            LVL_OPEN:   code_o = CODE_OPEN;
            LVL_WPROT:  code_o = CODE_WPROT;
            LVL_LOCKED: code_o = CODE_LOCKED;
            default:    code_o = CODE_OPEN;
        endcase
    end

endmodule

// File: rtl/sec_perm_matrix.sv
module sec_perm_matrix
    import sec_gate_pkg::*;
(
    input  lvl_e              lvl_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              grant_o,
    output logic [BYTE_W-1:0] err_o,
    output logic              raise_o,
    output lvl_e              target_o,
    output logic              wipe_o
);

    logic       is_read, is_write, is_free, is_sec;
    logic       allow_rd, allow_wr;
    logic [1:0] want_rank;
    logic       sec_ok;

    // operation classification
    always_comb begin
        is_read  = (op_i == OP_MEM_RD) || (op_i == OP_CFG_RD);
        is_write = (op_i == OP_MEM_WR) || (op_i == OP_BLK_ERASE) ||
                   (op_i == OP_CFG_WR);
        is_free  = (op_i == OP_ID_RD) || (op_i == OP_BLANK_CHK) ||
                   (op_i == OP_FULL_ERASE);
        is_sec   = (op_i == OP_SEC_WR);
    end

    // per-level allow rules
    always_comb begin
        unique case (lvl_i)
            LVL_OPEN:   begin allow_rd = 1'b1; allow_wr = 1'b1; end
            LVL_WPROT:  begin allow_rd = 1'b1; allow_wr = 1'b0; end
            LVL_LOCKED: begin allow_rd = 1'b0; allow_wr = 1'b0; end
            default:    begin allow_rd = 1'b0; allow_wr = 1'b0; end
        endcase
    end

    // security write: requested rank must be a level and strictly higher
    always_comb begin
        want_rank = code_rank(data_i);
        sec_ok    = (want_rank != 2'd3) && (want_rank > 2'(lvl_i));
        unique case (want_rank)
            2'd1:    target_o = LVL_WPROT;
            2'd2:    target_o = LVL_LOCKED;
            default: target_o = LVL_OPEN;
        endcase
    end

    always_comb begin
        grant_o = is_free || (is_read && allow_rd) ||
                  (is_write && allow_wr) || (is_sec && sec_ok);
        if (grant_o) begin
            err_o = REPLY_NONE;
        end else if (is_read) begin
            err_o = REPLY_RD_DENY;
        end else begin
            err_o = REPLY_WR_DENY;
        end
        raise_o = is_sec && sec_ok;
        wipe_o  = (op_i == OP_FULL_ERASE);
    end

endmodule

// File: rtl/sec_boot_cfg.sv
module sec_boot_cfg
    import sec_gate_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RST_STATUS = 8'hFF,
    parameter logic [BYTE_W-1:0] RST_VECTOR = 8'hFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              sel_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              wipe_i,
    output logic [BYTE_W-1:0] status_o,
    output logic [BYTE_W-1:0] vector_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_o <= RST_STATUS;
            vector_o <= RST_VECTOR;
        end else if (wipe_i) begin
            status_o <= RST_STATUS;
            vector_o <= RST_VECTOR;
        end else if (wr_en_i) begin
            if (sel_i) begin
                vector_o <= data_i;
            end else begin
                status_o <= data_i;
            end
        end
    end

endmodule

// File: rtl/sec_level_gate.sv
module sec_level_gate
    import sec_gate_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RST_STATUS = 8'hFF,
    parameter logic [BYTE_W-1:0] RST_VECTOR = 8'hFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [OP_W-1:0]   req_op,
    input  logic [BYTE_W-1:0] req_data,
    input  logic              req_cfg_sel,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic [BYTE_W-1:0] rsp_err,
    output logic [BYTE_W-1:0] sec_level,
    output logic [BYTE_W-1:0] boot_status,
    output logic [BYTE_W-1:0] boot_vector
);

    lvl_e              lvl;
    lvl_e              target;
    logic              grant, raise, wipe;
    logic [BYTE_W-1:0] err;

    sec_perm_matrix u_matrix (
        .lvl_i    (lvl),
        .op_i     (req_op),
        .data_i   (req_data),
        .grant_o  (grant),
        .err_o    (err),
        .raise_o  (raise),
        .target_o (target),
        .wipe_o   (wipe)
    );

    sec_level_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .raise_i  (req_valid && raise),
        .target_i (target),
        .wipe_i   (req_valid && wipe),
        .lvl_o    (lvl),
        .code_o   (sec_level)
    );

    sec_boot_cfg #(
        .RST_STATUS (RST_STATUS),
        .RST_VECTOR (RST_VECTOR)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (req_valid && grant && (req_op == OP_CFG_WR)),
        .sel_i    (req_cfg_sel),
        .data_i   (req_data),
        .wipe_i   (req_valid && wipe),
        .status_o (boot_status),
        .vector_o (boot_vector)
    );

    // one-cycle registered response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_err   <= REPLY_NONE;
        end else begin
            rsp_valid <= req_valid;
            rsp_grant <= req_valid && grant;
            rsp_err   <= req_valid ? err : REPLY_NONE;
        end
    end

endmodule

// File: rtl/sec_level_gate_chk.sv
module sec_level_gate_chk
    import sec_gate_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [OP_W-1:0]   req_op,
    input logic [BYTE_W-1:0] req_data,
    input logic              rsp_valid,
    input logic              rsp_grant,
    input logic [BYTE_W-1:0] rsp_err,
    input logic [BYTE_W-1:0] sec_level,
    input logic [BYTE_W-1:0] boot_status,
    input logic [BYTE_W-1:0] boot_vector
);

    logic [1:0] cur_rank, req_rank;
    assign cur_rank = code_rank(sec_level);
    assign req_rank = code_rank(req_data);

    a_r2_rsp_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_grant && rsp_err == REPLY_NONE));

    a_r6_level_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_op == OP_FULL_ERASE) |=> cur_rank >= $past(cur_rank));

    a_r7_bad_raise_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_SEC_WR && (req_rank == 2'd3 || req_rank <= cur_rank))
        |=> (!rsp_grant && rsp_err == REPLY_WR_DENY && $stable(sec_level)));

    a_r8_full_erase_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_FULL_ERASE)
        |=> (rsp_grant && sec_level == CODE_OPEN && boot_status == 8'hFF &&
             boot_vector == 8'hFC));

    a_r5_locked_read_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sec_level == CODE_LOCKED &&
         (req_op == OP_MEM_RD || req_op == OP_CFG_RD))
        |=> (!rsp_grant && rsp_err == REPLY_RD_DENY));

    a_r4_wprot_write_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sec_level == CODE_WPROT &&
         (req_op == OP_MEM_WR || req_op == OP_BLK_ERASE || req_op == OP_CFG_WR))
        |=> (!rsp_grant && rsp_err == REPLY_WR_DENY));

    a_r9_refused_cfg_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sec_level != CODE_OPEN && req_op == OP_CFG_WR)
        |=> ($stable(boot_status) && $stable(boot_vector)));

    a_r10_reserved_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op > OP_BLANK_CHK)
        |=> (!rsp_grant && rsp_err == REPLY_WR_DENY && $stable(sec_level)));

endmodule

bind sec_level_gate sec_level_gate_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_data    (req_data),
    .rsp_valid   (rsp_valid),
    .rsp_grant   (rsp_grant),
    .rsp_err     (rsp_err),
    .sec_level   (sec_level),
    .boot_status (boot_status),
    .boot_vector (boot_vector)
);

// File: tb/sec_level_gate_tb_top.sv
module sec_level_gate_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_op = 4'd0;
    logic [7:0] req_data = 8'd0;
    logic       req_cfg_sel = 1'b0;
    logic       rsp_valid, rsp_grant;
    logic [7:0] rsp_err, sec_level, boot_status, boot_vector;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model state
    logic [7:0] m_level  = 8'hFF;
    logic [7:0] m_status = 8'hFF;
    logic [7:0] m_vector = 8'hFC;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_level_gate dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_data    (req_data),
        .req_cfg_sel (req_cfg_sel),
        .rsp_valid   (rsp_valid),
        .rsp_grant   (rsp_grant),
        .rsp_err     (rsp_err),
        .sec_level   (sec_level),
        .boot_status (boot_status),
        .boot_vector (boot_vector)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int rank_of(input logic [7:0] c);
        if (c == 8'hFF) return 0;
        if (c == 8'hFE) return 1;
        if (c == 8'hFC) return 2;
        return -1;
    endfunction

    // expected {grant, err} from the requirement tables
    function automatic logic [8:0] expect_rsp(input logic [7:0] lvl,
                                              input logic [3:0] op,
                                              input logic [7:0] data);
        int r;
        r = rank_of(lvl);
        case (op)
            4'd6, 4'd7, 4'd8: return {1'b1, 8'h00};
            4'd0, 4'd4:       return (r < 2) ? {1'b1, 8'h00} : {1'b0, 8'h4C};
            4'd1, 4'd2, 4'd3: return (r == 0) ? {1'b1, 8'h00} : {1'b0, 8'h50};
            4'd5:             return (rank_of(data) > r) ? {1'b1, 8'h00} : {1'b0, 8'h50};
            default:          return {1'b0, 8'h50};
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] lvl, input logic [3:0] op,
                                     input logic [7:0] data);
        if (op > 4'd8) return "R10";
        if (op == 4'd7) return "R8";
        if (op == 4'd5) return (rank_of(data) > rank_of(lvl)) ? "R6" : "R7";
        if (op == 4'd3) return "R9";
        if (lvl == 8'hFF) return "R3";
        if (lvl == 8'hFE) return "R4";
        return "R5";
    endfunction

    // drive one request at a falling edge, check after the next rising edge
    task automatic do_req(input logic [3:0] op, input logic [7:0] data,
                          input logic sel, input string tag);
        logic [8:0] e;
        e = expect_rsp(m_level, op, data);
        req_valid   = 1'b1;
        req_op      = op;
        req_data    = data;
        req_cfg_sel = sel;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (e[8]) begin
            if (op == 4'd7) begin
                m_level = 8'hFF; m_status = 8'hFF; m_vector = 8'hFC;
            end else if (op == 4'd5) begin
                m_level = data;
            end else if (op == 4'd3) begin
                if (sel) m_vector = data; else m_status = data;
            end
        end
        chk(tag, "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(tag, "grant/err", {23'd0, rsp_grant, rsp_err}, {23'd0, e});
        chk(tag, "level/status/vector", {8'd0, sec_level, boot_status, boot_vector},
            {8'd0, m_level, m_status, m_vector});
    endtask

    task automatic idle_chk();
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R2", "idle valid/grant/err", {23'd0, rsp_valid, rsp_grant, rsp_err}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] pick [4];
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "level/status/vector", {8'd0, sec_level, boot_status, boot_vector},
            32'h00FFFFFC);
        chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        idle_chk();

        // R3: all classes at the open level (state-changing ones chosen harmlessly)
        for (int op = 0; op < 9; op++) begin
            if (op == 5) do_req(4'(op), 8'hFF, 1'b0, "R7");
            else if (op == 3) do_req(4'(op), 8'h5A, 1'b0, "R9");
            else do_req(4'(op), 8'h00, 1'b0, "R3");
        end
        do_req(4'd3, 8'h21, 1'b1, "R9");
        idle_chk();
        do_req(4'd5, 8'h77, 1'b0, "R7");
        do_req(4'd12, 8'hFE, 1'b0, "R10");
        // raise to FEh
        do_req(4'd5, 8'hFE, 1'b0, "R6");
        for (int op = 0; op < 7; op++) begin
            if (op == 5) do_req(4'(op), 8'hFE, 1'b0, "R7");
            else if (op == 3) do_req(4'(op), 8'h99, 1'b1, "R9");
            else do_req(4'(op), 8'h00, 1'b0, "R4");
        end
        do_req(4'd8, 8'h00, 1'b0, "R4");
        do_req(4'd5, 8'hFF, 1'b0, "R7");
        do_req(4'd15, 8'hFF, 1'b0, "R10");
        // raise to FCh
        do_req(4'd5, 8'hFC, 1'b0, "R6");
        for (int op = 0; op < 7; op++) begin
            if (op == 5) do_req(4'(op), 8'hFE, 1'b0, "R7");
            else if (op == 3) do_req(4'(op), 8'h11, 1'b0, "R9");
            else do_req(4'(op), 8'h00, 1'b0, "R5");
        end
        do_req(4'd8, 8'h00, 1'b0, "R5");
        do_req(4'd5, 8'hFC, 1'b0, "R7");
        do_req(4'd9, 8'h00, 1'b0, "R10");
        do_req(4'd7, 8'h00, 1'b0, "R8");
        // open straight to locked
        do_req(4'd5, 8'hFC, 1'b0, "R6");
        do_req(4'd7, 8'h00, 1'b0, "R8");
        idle_chk();

        // seeded random mix
        pick[0] = 8'hFF; pick[1] = 8'hFE; pick[2] = 8'hFC;
        for (int i = 0; i < 400; i++) begin
            logic [3:0] op;
            logic [7:0] d;
            logic       s;
            op = 4'($urandom % 16);
            pick[3] = 8'($urandom);
            d  = pick[$urandom % 4];
            s  = 1'($urandom);
            do_req(op, d, s, tag_of(m_level, op, d));
            if (($urandom % 8) == 0) idle_chk();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule